// File: doc/BRIEF.md
# Subchannel Address/Count Interlace Controller

This block steers one direct-memory subchannel. It keeps the memory address of the next word to move and the number of words still to move in the current record. Both values come from an interlace word that the block reads from memory when it is activated. That word holds an 8-bit count in bits [23:16] and a 16-bit word address in bits [15:0]. Each time the subchannel reports a transferred word, the address moves forward by one and the count drops by one. When the last word of a record has gone, the block can pulse a program interrupt request, a device notification, or both.

In alternate-buffer mode the block keeps a pair of interlace words at consecutive memory locations. When one record runs out, it fetches the other interlace word by itself and carries on, so a continuous stream never waits for software. The active buffer index is visible on a status pin. The memory array, arbitration for memory and character packing belong to neighbouring logic.

Top module: `ilv_subchan`

## Requirements
- R1: After reset, memReq, ready, active, bufSel, irqPulse and devNotify are 0, and xferAddr and xferCount are 0.
- R2: A one-cycle actStrobe while active is 0 latches ptrBase, altMode, irqEn and notifyEn, and clears bufSel. From the next cycle memReq is 1 with memAddr equal to ptrBase plus bufSel. memReq and memAddr stay steady until a cycle with memAck = 1. An actStrobe while active is 1 has no effect.
- R3: In the cycle where memReq and memAck are both 1, memData is taken in: bits [15:0] go to xferAddr and bits [23:16] go to xferCount. In the next cycle ready is 1 and memReq is 0.
- R4: A xferDone pulse while ready is 1 sets xferAddr to xferAddr+1 and xferCount to xferCount-1 (modulo 256) in the next cycle. A xferDone pulse while ready is 0 leaves both unchanged.
- R5: A count field of N (1 to 255) gives a record of exactly N words, and a count field of 0 gives a record of 256 words.
- R6: In the cycle after the last word of a record, irqPulse is 1 for exactly one cycle if irqEn was latched as 1. devNotify behaves the same way with notifyEn. Neither pulses at any other time.
- R7: In single-buffer mode (altMode latched as 0), active and ready are 0 from the cycle after the last word, and bufSel stays 0.
- R8: In alternate-buffer mode (altMode latched as 1), bufSel toggles in the cycle after the last word. Then ready is 0 and memReq is 1, fetching from ptrBase+1 after buffer 0 and from ptrBase after buffer 1. The new record starts as in R3.
- R9: The address wraps from 16'hFFFF to 16'h0000 within a record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| actStrobe | input | 1 | Activate the subchannel (pulse) |
| altMode | input | 1 | 1 = alternate between two interlace words |
| irqEn | input | 1 | Pulse irqPulse at the end of each record |
| notifyEn | input | 1 | Pulse devNotify at the end of each record |
| ptrBase | input | 16 | Memory location of interlace word 0 (word 1 is the next location) |
| memReq | output | 1 | Interlace-word read request |
| memAddr | output | 16 | Read address |
| memAck | input | 1 | Read completes; memData is valid |
| memData | input | 24 | Interlace word: count [23:16], address [15:0] |
| xferDone | input | 1 | One word transferred (pulse) |
| ready | output | 1 | Address and count are valid; transfers accepted |
| active | output | 1 | Subchannel is activated |
| xferAddr | output | 16 | Address of the next word to transfer |
| xferCount | output | 8 | Remaining-count register |
| bufSel | output | 1 | Index of the interlace word in use |
| irqPulse | output | 1 | End-of-record interrupt request |
| devNotify | output | 1 | End-of-record device notification |

## Verification
The hardest case to reach is the buffer switch after a full 256-word record whose address also wraps through zero. That moment needs a zero count field, an address close to the top of memory and the alternate mode all at once, and then 256 accepted transfers. The stimulus loads such a word with a read latency of one cycle and steps through every word, checking each one. It then confirms that the second interlace word is fetched from the next location and that the first one is fetched again after that. A scoreboard holds the expected fetch addresses and end-of-record pulses. A fetch or pulse that was not expected, such as one caused by an activation while the subchannel is already running, counts as a failure.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } ilvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;  // capture base pointer and mode bits, clear buffer index
    logic loadWord;  // take in the interlace word returned by memory
    logic stepWord;  // one word moved: address up, count down
    logic flipBuf;   // switch to the other interlace word
    logic endMark;   // last word of a record just moved
  } ilvStrobe_t;

endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       actStrobe,
  input  logic       memAck,
  input  logic       xferDone,
  input  logic       cntIsOne,
  input  logic       altLatched,
  output ilvStrobe_t stb,
  output logic       memReq,
  output logic       ready,
  output logic       active
);

  ilvState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (actStrobe) begin
          stb.latchCfg = 1'b1;
          nextState    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memAck) begin
          stb.loadWord = 1'b1;
          nextState    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (xferDone) begin
          stb.stepWord = 1'b1;
          if (cntIsOne) begin
            stb.endMark = 1'b1;
            if (altLatched) begin
              stb.flipBuf = 1'b1;
              nextState   = ST_FETCH;
            end else begin
              nextState   = ST_IDLE;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_FETCH);
  assign ready  = (state == ST_RUN);
  assign active = (state != ST_IDLE);

endmodule

// File: rtl/ilv_dpath.sv
module ilv_dpath
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  localparam int WORD_W = ADDR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ilvStrobe_t        stb,
  input  logic [ADDR_W-1:0] ptrBase,
  input  logic              altMode,
  input  logic              irqEn,
  input  logic              notifyEn,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic              bufSel,
  output logic              irqPulse,
  output logic              devNotify,
  output logic              cntIsOne,
  output logic              altLatched
);

  logic [ADDR_W-1:0] ptrReg;
  logic              irqEnReg, ntfEnReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg     <= '0;
      altLatched <= 1'b0;
      irqEnReg   <= 1'b0;
      ntfEnReg   <= 1'b0;
      bufSel     <= 1'b0;
    end else if (stb.latchCfg) begin
      ptrReg     <= ptrBase;
      altLatched <= altMode;
      irqEnReg   <= irqEn;
      ntfEnReg   <= notifyEn;
      bufSel     <= 1'b0;
    end else if (stb.flipBuf) begin
      bufSel     <= ~bufSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferAddr  <= '0;
      xferCount <= '0;
    end else if (stb.loadWord) begin
      xferAddr  <= memData[ADDR_W-1:0];
      xferCount <= memData[WORD_W-1:ADDR_W];
    end else if (stb.stepWord) begin
      xferAddr  <= xferAddr + 1'b1;
      xferCount <= xferCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse  <= 1'b0;
      devNotify <= 1'b0;
    end else begin
      irqPulse  <= stb.endMark & irqEnReg;
      devNotify <= stb.endMark & ntfEnReg;
    end
  end

  assign memAddr  = ptrReg + {{(ADDR_W-1){1'b0}}, bufSel};
  assign cntIsOne = (xferCount == CNT_W'(1));

endmodule

// File: rtl/ilv_subchan.sv
module ilv_subchan
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  localparam int WORD_W = ADDR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              actStrobe,
  input  logic              altMode,
  input  logic              irqEn,
  input  logic              notifyEn,
  input  logic [ADDR_W-1:0] ptrBase,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memData,
  input  logic              xferDone,
  output logic              ready,
  output logic              active,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic              bufSel,
  output logic              irqPulse,
  output logic              devNotify
);

  ilvStrobe_t stb;
  logic       cntIsOne, altLatched;

  ilv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .actStrobe(actStrobe), .memAck(memAck),
    .xferDone(xferDone), .cntIsOne(cntIsOne), .altLatched(altLatched),
    .stb(stb), .memReq(memReq), .ready(ready), .active(active)
  );

  ilv_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .ptrBase(ptrBase), .altMode(altMode),
    .irqEn(irqEn), .notifyEn(notifyEn), .memData(memData), .memAddr(memAddr),
    .xferAddr(xferAddr), .xferCount(xferCount), .bufSel(bufSel),
    .irqPulse(irqPulse), .devNotify(devNotify), .cntIsOne(cntIsOne),
    .altLatched(altLatched)
  );

endmodule

// File: rtl/ilv_subchan_chk.sv
module ilv_subchan_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              actStrobe,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              xferDone,
  input logic              ready,
  input logic              active,
  input logic [ADDR_W-1:0] xferAddr,
  input logic [CNT_W-1:0]  xferCount,
  input logic              bufSel,
  input logic              irqPulse,
  input logic              devNotify
);

  logic lastWord;
  assign lastWord = ready && xferDone && (xferCount == CNT_W'(1));

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr)); // R2
  AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> ready && !memReq); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ready && xferDone |=> xferAddr == ADDR_W'($past(xferAddr) + 1'b1)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ready && xferDone |=> xferCount == CNT_W'($past(xferCount) - 1'b1)); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ready && !memAck |=> $stable(xferAddr) && $stable(xferCount)); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse || devNotify |-> $past(lastWord)); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R6
  AST_BUF_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    !lastWord && !(actStrobe && !active) |=> $stable(bufSel)); // R8

endmodule

bind ilv_subchan ilv_subchan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .actStrobe(actStrobe), .memReq(memReq),
  .memAddr(memAddr), .memAck(memAck), .xferDone(xferDone), .ready(ready),
  .active(active), .xferAddr(xferAddr), .xferCount(xferCount),
  .bufSel(bufSel), .irqPulse(irqPulse), .devNotify(devNotify)
);

// File: tb/sim_ilv_subchan.sv
module sim_ilv_subchan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        actStrobe = 1'b0, altMode = 1'b0, irqEn = 1'b0, notifyEn = 1'b0;
  logic [15:0] ptrBase = '0;
  logic        memReq, memAck = 1'b0;
  logic [15:0] memAddr;
  logic [23:0] memData = '0;
  logic        xferDone = 1'b0;
  logic        ready, active, bufSel, irqPulse, devNotify;
  logic [15:0] xferAddr;
  logic [7:0]  xferCount;

  always #2 clk = ~clk;  // 250 MHz

  ilv_subchan u0 (
    .clk(clk), .rstN(rstN), .actStrobe(actStrobe), .altMode(altMode),
    .irqEn(irqEn), .notifyEn(notifyEn), .ptrBase(ptrBase), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData), .xferDone(xferDone),
    .ready(ready), .active(active), .xferAddr(xferAddr), .xferCount(xferCount),
    .bufSel(bufSel), .irqPulse(irqPulse), .devNotify(devNotify)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [15:0] fetchQ[$];
  logic [1:0]  endQ[$];
  logic        reqPrev = 1'b0;

  // monitor
  always @(negedge clk) begin
    if (!rstN) reqPrev = 1'b0;
    else begin
      if (memReq && !reqPrev) begin
        if (fetchQ.size() == 0) chk(1'b0, "R2 unexpected fetch", {16'h0, memAddr}, 32'h0);
        else begin
          logic [15:0] e;
          e = fetchQ.pop_front();
          chk(memAddr == e, "R2/R8 fetch address", {16'h0, memAddr}, {16'h0, e});
        end
      end
      reqPrev = memReq;
      if (irqPulse || devNotify) begin
        if (endQ.size() == 0) chk(1'b0, "R6 unexpected pulse", {30'h0, irqPulse, devNotify}, 32'h0);
        else begin
          logic [1:0] e;
          e = endQ.pop_front();
          chk({irqPulse, devNotify} == e, "R6 end pulses", {30'h0, irqPulse, devNotify}, {30'h0, e});
        end
      end
    end
  end

  // memory responder
  logic [15:0] baseA = '0;
  logic [23:0] wordA = '0, wordB = '0;
  int memLat = 0, waitCnt = 0;
  always @(posedge clk) begin
    #1;
    if (!rstN) begin memAck = 1'b0; waitCnt = 0; end
    else if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (waitCnt >= memLat) begin
        memAck  = 1'b1;
        memData = (memAddr == baseA) ? wordA : wordB;
        waitCnt = 0;
      end else waitCnt++;
    end
  end

  // expected state kept by the driver
  logic [15:0] eAddr;
  logic [7:0]  eCnt;
  logic        eBuf, eAlt, eIrq, eNtf;

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    fetchQ.delete();
    endQ.delete();
    #1 rstN = 1'b1;
  endtask

  task automatic activate(input logic [15:0] base, input logic alt, input logic ie, input logic ne);
    @(posedge clk); #1;
    ptrBase = base; altMode = alt; irqEn = ie; notifyEn = ne;
    eAlt = alt; eIrq = ie; eNtf = ne; eBuf = 1'b0; baseA = base;
    fetchQ.push_back(base);
    actStrobe = 1'b1;
    @(posedge clk); #1 actStrobe = 1'b0;
  endtask

  task automatic waitReady();
    while (!ready) begin @(posedge clk); #1; end
  endtask

  task automatic loadCheck(input logic [23:0] w);
    waitReady();
    eAddr = w[15:0];
    eCnt  = w[23:16];
    chk(xferAddr == eAddr, "R3 address field", {16'h0, xferAddr}, {16'h0, eAddr});
    chk(xferCount == eCnt, "R3 count field", {24'h0, xferCount}, {24'h0, eCnt});
    chk(!memReq, "R3 request dropped", {31'h0, memReq}, 32'h0);
  endtask

  task automatic step();
    waitReady();
    if (eCnt == 8'd1) begin
      if (eIrq || eNtf) endQ.push_back({eIrq, eNtf});
      if (eAlt) begin
        eBuf = ~eBuf;
        fetchQ.push_back(baseA + {15'h0, eBuf});
      end
    end
    xferDone = 1'b1;
    @(posedge clk); #1 xferDone = 1'b0;
    eAddr = eAddr + 16'd1;
    eCnt  = eCnt - 8'd1;
    chk(xferAddr == eAddr, "R4 address step", {16'h0, xferAddr}, {16'h0, eAddr});
    chk(xferCount == eCnt, "R4 count step", {24'h0, xferCount}, {24'h0, eCnt});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    // R1 reset state
    chk({memReq, ready, active, bufSel, irqPulse, devNotify} == 6'b0, "R1 control outputs",
        {26'h0, memReq, ready, active, bufSel, irqPulse, devNotify}, 32'h0);
    chk(xferAddr == 16'h0 && xferCount == 8'h0, "R1 registers", {8'h0, xferCount, xferAddr}, 32'h0);

    // single-buffer record of 3 words, interrupt only, slow memory
    wordA = {8'd3, 16'h1234}; memLat = 2;
    activate(16'h0100, 1'b0, 1'b1, 1'b0);
    chk(!ready && active, "R2 fetching", {30'h0, ready, active}, 32'h1);
    loadCheck(wordA);
    // activation while running is ignored (R2)
    @(posedge clk); #1 actStrobe = 1'b1;
    @(posedge clk); #1 actStrobe = 1'b0;
    @(negedge clk);
    chk(ready && !memReq && xferAddr == 16'h1234, "R2 activation ignored", {15'h0, ready, xferAddr}, {15'h0, 1'b1, 16'h1234});
    repeat (3) step();
    @(negedge clk);
    chk(!active && !ready && !bufSel, "R7 stop after record", {29'h0, active, ready, bufSel}, 32'h0);
    // transfer pulse while not ready is ignored (R4)
    @(posedge clk); #1 xferDone = 1'b1;
    @(posedge clk); #1 xferDone = 1'b0;
    @(negedge clk);
    chk(xferAddr == 16'h1237 && xferCount == 8'h0, "R4 ignored when idle", {8'h0, xferCount, xferAddr}, 32'h1237);

    // one-word record, notification only, zero-latency memory (R5)
    wordA = {8'd1, 16'h7000}; memLat = 0;
    activate(16'h0200, 1'b0, 1'b0, 1'b1);
    loadCheck(wordA);
    step();
    @(negedge clk);
    chk(!active, "R5 one-word record", {31'h0, active}, 32'h0);

    // alternate buffers: 256-word record wrapping through zero, then 2 words
    doReset();
    wordA = {8'd0, 16'hFFFE}; wordB = {8'd2, 16'h0040}; memLat = 1;
    activate(16'h0300, 1'b1, 1'b1, 1'b1);
    loadCheck(wordA);
    step(); step();
    chk(xferAddr == 16'h0000, "R9 address wrap", {16'h0, xferAddr}, 32'h0);
    for (int i = 0; i < 254; i++) step();
    @(negedge clk);
    chk(xferCount == 8'h0 && xferAddr == 16'h00FE, "R5 256-word record", {8'h0, xferCount, xferAddr}, 32'h00FE);
    chk(!ready && active && bufSel, "R8 switch to buffer 1", {29'h0, ready, active, bufSel}, 32'h3);
    loadCheck(wordB);
    step(); step();
    @(negedge clk);
    chk(!bufSel && active, "R8 switch back to buffer 0", {30'h0, bufSel, active}, 32'h1);
    loadCheck(wordA);

    repeat (4) @(negedge clk);
    chk(fetchQ.size() == 0, "R8 all fetches seen", fetchQ.size(), 32'h0);
    chk(endQ.size() == 0, "R6 all pulses seen", endQ.size(), 32'h0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule